// File: doc/BRIEF.md
# Edge-Triggered Event Request Channel

This block is a single channel of an event request unit. It receives two asynchronous request lines, A and B, and brings each into the clock domain. Each line can be inverted on its own, and the two are then combined into one event source. The source is A, B, A OR B, or A AND B. The channel watches that source for rising and falling edges and keeps a status flag. The flag is either sticky or tracks the level of the event.

When pulse generation is enabled, every enabled edge produces a one-cycle trigger on one line of a small one-hot vector. A channel-select field picks the line. Each line feeds a separate downstream gating unit.

All configuration and the flag sit in one 32-bit control word. The word is written through a simple synchronous port, and its current value is always visible on the read data output. Software may overwrite the flag, but a hardware flag update in the same cycle wins.

Top module: `evtrig_chan`

## Requirements
- R1: While reset is asserted and right after it, the read data is all zero and no trigger line is high.
- R2: A write stores bits 11:0 of the write data, and they read back from the next cycle on. The field positions are: bit 0 pulse enable, bit 1 level mode, bit 2 rising enable, bit 3 falling enable, bits 6:4 channel select, bit 7 flag, bits 9:8 source select, bit 10 invert A, bit 11 invert B. Bits 31:12 always read zero.
- R3: The event source is chosen by source select: 0 gives A, 1 gives B, 2 gives A OR B, 3 gives A AND B. The invert bits act on each input before the two are combined.
- R4: A rising edge of the source is an enabled event only when the rising enable is 1. A falling edge is an enabled event only when the falling enable is 1.
- R5: With level mode 0, an enabled event sets the flag. The flag then stays at 1 through any later edges until a write clears it.
- R6: With level mode 1, a rising edge loads the flag with the rising enable, and a falling edge loads it with the falling enable.
- R7: With pulse enable 1, each enabled event raises exactly one trigger line, bit number equal to the channel select, for exactly one cycle. With pulse enable 0, no line rises.
- R8: Channel select values 4 to 7 raise no trigger line. The flag is still updated as usual.
- R9: An input change reaches the flag and the trigger on the third rising clock edge after it is applied: two synchronizer stages, then the result register.
- R10: A write replaces the flag with write data bit 7. When a hardware flag update falls in the same cycle as the write, the hardware value is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_a_i | input | 1 | Asynchronous request input A |
| req_b_i | input | 1 | Asynchronous request input B |
| reg_we_i | input | 1 | Control word write enable |
| reg_wdata_i | input | 32 | Control word write data |
| reg_rdata_o | output | 32 | Current control word including the flag |
| trig_o | output | 4 | One-hot trigger pulse to the gating units |

## Verification
Suppose the registered copy of the source held a wrong value. A missing or spurious trigger would then appear on trig_o one cycle after the edge was due, and the flag bit would go wrong in the same cycle. A wrong synchronizer depth moves both of these by whole cycles away from the third edge. A flag that lost its sticky behaviour, or that let a write win over a hardware update, would show on the read data one cycle later and stay wrong until the next edge or write. The bench compares trig_o and the whole read word against an independent cycle model on every cycle. A single-cycle disagreement is therefore caught at once.

// File: rtl/evtrig_pkg.sv
package evtrig_pkg;

   localparam int CHSEL_W = 3;
   localparam int SRCSEL_W = 2;

   typedef enum logic [SRCSEL_W-1:0] {
      SRC_A   = 2'd0,
      SRC_B   = 2'd1,
      SRC_OR  = 2'd2,
      SRC_AND = 2'd3
   } src_sel_e;

   // Packed MSB first, so the field bit positions match the control word
   typedef struct packed {
      logic               inv_b;
      logic               inv_a;
      src_sel_e           src_sel;
      logic               flag;
      logic [CHSEL_W-1:0] chan;
      logic               fall_en;
      logic               rise_en;
      logic               lvl_mode;
      logic               pulse_en;
   } ctrl_t;

   localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/evtrig_sync.sv
module evtrig_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   if (STAGES < 2) begin : g_bad_depth
      $error("evtrig_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stg_q [STAGES];

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
      end else begin
         stg_q[0] <= d_i;
         for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
      end
   end

   assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/evtrig_src.sv
module evtrig_src
   import evtrig_pkg::*;
(
   input  logic     a_i,
   input  logic     b_i,
   input  logic     inv_a_i,
   input  logic     inv_b_i,
   input  src_sel_e sel_i,
   output logic     src_o
);

   logic a_eff, b_eff;

   assign a_eff = a_i ^ inv_a_i;
   assign b_eff = b_i ^ inv_b_i;

   always_comb begin
      unique case (sel_i)
         SRC_A:   src_o = a_eff;
         SRC_B:   src_o = b_eff;
         SRC_OR:  src_o = a_eff | b_eff;
         SRC_AND: src_o = a_eff & b_eff;
         default: src_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/evtrig_detect.sv
module evtrig_detect (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic src_i,
   input  logic rise_en_i,
   input  logic fall_en_i,
   input  logic lvl_mode_i,
   input  logic sw_we_i,
   input  logic sw_flag_i,
   output logic evt_o,
   output logic flag_o
);

   logic src_q, flag_q;
   logic rise, fall;
   logic hw_upd, hw_val;

   assign rise  = src_i & ~src_q;
   assign fall  = ~src_i & src_q;
   assign evt_o = (rise & rise_en_i) | (fall & fall_en_i);

   // Level mode: every edge rewrites the flag; sticky mode: only enabled events set it
   assign hw_upd = lvl_mode_i ? (rise | fall) : evt_o;
   assign hw_val = lvl_mode_i ? (rise ? rise_en_i : fall_en_i) : 1'b1;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         src_q  <= 1'b0;
         flag_q <= 1'b0;
      end else begin
         src_q <= src_i;
         if (hw_upd)       flag_q <= hw_val;
         else if (sw_we_i) flag_q <= sw_flag_i;
      end
   end

   assign flag_o = flag_q;

endmodule

// File: rtl/evtrig_route.sv
module evtrig_route #(
   parameter int NUM_OUT = 4,
   parameter int SEL_W   = 3
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               fire_i,
   input  logic [SEL_W-1:0]   sel_i,
   output logic [NUM_OUT-1:0] trig_o
);

   logic [NUM_OUT-1:0] hit;
   logic [NUM_OUT-1:0] trig_q;

   for (genvar i = 0; i < NUM_OUT; i++) begin : g_line
      assign hit[i] = (sel_i == SEL_W'(i));
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) trig_q <= '0;
      else         trig_q <= fire_i ? hit : '0;
   end

   assign trig_o = trig_q;

endmodule

// File: rtl/evtrig_chan.sv
module evtrig_chan
   import evtrig_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int NUM_OUT     = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               req_a_i,
   input  logic               req_b_i,
   input  logic               reg_we_i,
   input  logic [DATA_W-1:0]  reg_wdata_i,
   output logic [DATA_W-1:0]  reg_rdata_o,
   output logic [NUM_OUT-1:0] trig_o
);

   localparam int PAD_W = DATA_W - CTRL_W;

   if (DATA_W <= CTRL_W) begin : g_bad_data_w
      $error("evtrig_chan: DATA_W must exceed the control field width");
   end
   if (NUM_OUT < 1 || NUM_OUT > (1 << CHSEL_W)) begin : g_bad_num_out
      $error("evtrig_chan: NUM_OUT must be in 1 .. 2**CHSEL_W");
   end

   ctrl_t cfg_q, wr_ctrl, rd_ctrl;
   logic  [1:0] req_s;
   logic  src, evt, flag;
   logic  unused_wdata;

   assign wr_ctrl      = ctrl_t'(reg_wdata_i[CTRL_W-1:0]);
   assign unused_wdata = ^reg_wdata_i[DATA_W-1:CTRL_W];

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cfg_q <= '0;
      end else if (reg_we_i) begin
         cfg_q      <= wr_ctrl;
         cfg_q.flag <= 1'b0;
      end
   end

   evtrig_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   ({req_b_i, req_a_i}),
      .q_o   (req_s)
   );

   evtrig_src u_src (
      .a_i    (req_s[0]),
      .b_i    (req_s[1]),
      .inv_a_i(cfg_q.inv_a),
      .inv_b_i(cfg_q.inv_b),
      .sel_i  (cfg_q.src_sel),
      .src_o  (src)
   );

   evtrig_detect u_det (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .src_i     (src),
      .rise_en_i (cfg_q.rise_en),
      .fall_en_i (cfg_q.fall_en),
      .lvl_mode_i(cfg_q.lvl_mode),
      .sw_we_i   (reg_we_i),
      .sw_flag_i (wr_ctrl.flag),
      .evt_o     (evt),
      .flag_o    (flag)
   );

   evtrig_route #(.NUM_OUT(NUM_OUT), .SEL_W(CHSEL_W)) u_route (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .fire_i(evt & cfg_q.pulse_en),
      .sel_i (cfg_q.chan),
      .trig_o(trig_o)
   );

   always_comb begin
      rd_ctrl      = cfg_q;
      rd_ctrl.flag = flag;
   end

   assign reg_rdata_o = {{PAD_W{1'b0}}, rd_ctrl};

endmodule

// File: rtl/evtrig_chan_chk.sv
module evtrig_chan_chk #(
   parameter int DATA_W  = 32,
   parameter int NUM_OUT = 4
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic               reg_we_i,
   input logic [DATA_W-1:0]  reg_wdata_i,
   input logic [DATA_W-1:0]  reg_rdata_o,
   input logic [NUM_OUT-1:0] trig_o
);

   // R7
   trig_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(trig_o));

   // R7
   trig_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (trig_o != '0) |-> $past(reg_rdata_o[0]));

   // R8
   trig_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (trig_o != '0) |-> (trig_o == (NUM_OUT'(1) << $past(reg_rdata_o[6:4]))));

   // R2
   cfg_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      reg_we_i |=> (reg_rdata_o[11:8] == $past(reg_wdata_i[11:8]) &&
                    reg_rdata_o[6:0]  == $past(reg_wdata_i[6:0])));

   // R5
   sticky_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_rdata_o[7] && !reg_rdata_o[1] && !reg_we_i) |=> reg_rdata_o[7]);

   // R10
   flag_set_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_we_i && reg_wdata_i[7] && !reg_rdata_o[1]) |=> reg_rdata_o[7]);

endmodule

bind evtrig_chan evtrig_chan_chk #(.DATA_W(DATA_W), .NUM_OUT(NUM_OUT)) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .reg_we_i   (reg_we_i),
   .reg_wdata_i(reg_wdata_i),
   .reg_rdata_o(reg_rdata_o),
   .trig_o     (trig_o)
);

// File: tb/evtrig_chan_tb_top.sv
`timescale 1ns/1ps
module evtrig_chan_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        a = 1'b0, b = 1'b0;
   logic        we = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [3:0]  trig;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   evtrig_chan dut_i (
      .clk_i(clk), .rst_ni(rst_n), .req_a_i(a), .req_b_i(b),
      .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .trig_o(trig)
   );

   // Reference model, built from the requirements
   logic        m_a1, m_a2, m_b1, m_b2, m_sq, m_flag;
   logic [11:0] m_cfg;
   logic [3:0]  m_trig;

   function automatic logic src_fn(logic fa, logic fb, logic [11:0] c);
      logic ea, eb;
      ea = fa ^ c[10];
      eb = fb ^ c[11];
      case (c[9:8])
         2'd0: return ea;
         2'd1: return eb;
         2'd2: return ea | eb;
         default: return ea & eb;
      endcase
   endfunction

   function automatic logic [31:0] exp_rd();
      return {20'b0, m_cfg[11:8], m_flag, m_cfg[6:0]};
   endfunction

   always @(posedge clk) begin
      logic s, ri, fa, ev, hu, hv;
      if (!rst_n) begin
         m_a1 = 0; m_a2 = 0; m_b1 = 0; m_b2 = 0; m_sq = 0; m_flag = 0;
         m_cfg = '0; m_trig = '0;
      end else begin
         s  = src_fn(m_a2, m_b2, m_cfg);
         ri = s & ~m_sq;
         fa = ~s & m_sq;
         ev = (ri & m_cfg[2]) | (fa & m_cfg[3]);
         hu = m_cfg[1] ? (ri | fa) : ev;
         hv = m_cfg[1] ? (ri ? m_cfg[2] : m_cfg[3]) : 1'b1;
         m_trig = (m_cfg[0] && ev && m_cfg[6:4] < 3'd4) ? (4'b1 << m_cfg[6:4]) : 4'b0;
         if (hu)      m_flag = hv;
         else if (we) m_flag = wdata[7];
         if (we) m_cfg = wdata[11:0];
         m_sq = s;
         m_a2 = m_a1; m_a1 = a;
         m_b2 = m_b1; m_b1 = b;
      end
   end

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // Cycle-by-cycle comparison against the model (R3 R4 R5 R6 R7 R8 R10)
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R2/R5/R6/R10 model rdata", rdata, exp_rd());
         chk("R3/R4/R7/R8 model trig", {28'b0, trig}, {28'b0, m_trig});
      end
   end

   task automatic wr(input logic [31:0] d);
      we = 1'b1; wdata = d;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic wait_lat();
      repeat (3) @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog R1 actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (4) @(negedge clk);
      chk("R1 reset rdata", rdata, 32'h0);
      chk("R1 reset trig", {28'b0, trig}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after reset rdata", rdata, 32'h0);

      // R2 readback, upper bits zero
      wr(32'hFFFF_F36D);
      chk("R2 readback", rdata, 32'h0000_036D);

      // R3 invert A makes source high: rising edge, pulse on line 2
      wr(32'h0000_0425);
      @(negedge clk);
      chk("R3 inverted A trig", {28'b0, trig}, 32'h4);
      chk("R5 flag set", {31'b0, rdata[7]}, 32'h1);
      @(negedge clk);
      chk("R7 pulse one cycle", {28'b0, trig}, 32'h0);
      wr(32'h0000_0425);
      chk("R10 software clear", {31'b0, rdata[7]}, 32'h0);

      // R9 latency and R10 collision
      wr(32'h0000_0015);
      @(negedge clk);
      a = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk("R9 not early", {28'b0, trig}, 32'h0);
      we = 1'b1; wdata = 32'h0000_0015;
      @(posedge clk);
      @(negedge clk);
      we = 1'b0;
      chk("R9 trig on third edge", {28'b0, trig}, 32'h2);
      chk("R10 hardware wins", {31'b0, rdata[7]}, 32'h1);

      // R6 level mode on B, rise disabled, fall enabled
      wr(32'h0000_010A);
      @(negedge clk);
      chk("R6 fall sets flag", {31'b0, rdata[7]}, 32'h1);
      b = 1'b1; wait_lat();
      chk("R6 rise clears flag", {31'b0, rdata[7]}, 32'h0);
      b = 1'b0; wait_lat();
      chk("R6 fall sets again", {31'b0, rdata[7]}, 32'h1);
      chk("R7 no pulse when disabled", {28'b0, trig}, 32'h0);

      // R8 channel 5 drives nothing
      wr(32'h0000_0155);
      @(negedge clk);
      b = 1'b1; wait_lat();
      chk("R8 no line for chan 5", {28'b0, trig}, 32'h0);
      chk("R8 flag still set", {31'b0, rdata[7]}, 32'h1);

      // R4 fall only
      wr(32'h0000_0139);
      @(negedge clk);
      b = 1'b0; wait_lat();
      chk("R4 fall enabled trig", {28'b0, trig}, 32'h8);
      wr(32'h0000_0139);
      b = 1'b1; wait_lat();
      chk("R4 rise ignored trig", {28'b0, trig}, 32'h0);
      chk("R4 rise ignored flag", {31'b0, rdata[7]}, 32'h0);

      // R5 sticky through later edges
      b = 1'b0; wait_lat();
      b = 1'b1; wait_lat();
      chk("R5 sticky after rise", {31'b0, rdata[7]}, 32'h1);

      // R3 AND combination
      wr(32'h0000_0305);
      @(negedge clk);
      a = 1'b0; wait_lat();
      b = 1'b0; a = 1'b1; wait_lat();
      chk("R3 AND one input low", {28'b0, trig}, 32'h0);
      b = 1'b1; wait_lat();
      chk("R3 AND both high", {28'b0, trig}, 32'h1);

      // Random phase
      for (int i = 0; i < 4000; i++) begin
         a = 1'($urandom % 2);
         b = 1'($urandom % 2);
         we = (($urandom % 10) == 0);
         wdata = $urandom;
         @(negedge clk);
      end
      we = 1'b0;
      repeat (4) @(negedge clk);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule